// File: doc/BRIEF.md
# Multimode Set/Reset Storage Register

This block holds a small group of bits that share one active-low enable and one active-low master reset. Each bit has its own data input and its own active-low set input. Together these two inputs decide how the bit behaves. With its set input tied low, a bit acts as a transparent D latch that follows its data input. With its set input driven, the bit acts as a set/reset cell. A low data input clears the bit. A low set input sets the bit, but only while data is high. Data wins when both are low.

The behaviour is modelled as a clocked register. Enable, data and set are sampled on each rising clock edge, and the new state appears on the output after that edge. The master reset is asynchronous. It clears every bit at once and overrides all other inputs. The bit count is a parameter and defaults to four. Each bit is evaluated on its own, using only the shared enable and reset.

Top module: `quad_sr_latch`

## Requirements
- R1: While `rst_ni` is low, every bit of `q_o` is 0, with no clock edge needed, whatever the other inputs are.
- R2: A rising edge that samples `en_ni` high leaves `q_o` unchanged, whatever `d_i` and `set_ni` are.
- R3: A rising edge that samples `en_ni` low clears every bit n whose `d_i[n]` is 0, whatever `set_ni[n]` is. When both are 0, the bit is cleared.
- R4: A rising edge that samples `en_ni` low sets every bit n with `d_i[n]`=1 and `set_ni[n]`=0.
- R5: A rising edge that samples `en_ni` low leaves a bit n unchanged when `d_i[n]`=1 and `set_ni[n]`=1.
- R6: With `set_ni[n]` held at 0 and `en_ni` low, `q_o[n]` equals the `d_i[n]` sampled at the previous rising edge (transparent D mode).
- R7: Each bit's next value depends only on its own `d_i` and `set_ni` bits, the shared `en_ni` and `rst_ni`, and its own state. Bits in different modes in the same cycle do not affect one another.
- R8: After `rst_ni` is released, the first rising edge already applies R2 to R5 to the sampled inputs. When enable goes high, the state held is the one from the last enabled edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock, rising edge |
| rst_ni | input | 1 | Master reset, active low, asynchronous |
| en_ni | input | 1 | Shared enable, active low |
| d_i | input | WIDTH | Per-bit data input; low clears |
| set_ni | input | WIDTH | Per-bit set input, active low |
| q_o | output | WIDTH | Stored bit values |

## Verification
Enable, data and set take effect on `q_o` after the first rising edge that samples them. The bench therefore drives inputs on a falling edge, lets one rising edge pass, and compares `q_o` at the next falling edge against a model that applied the same rule on that edge. The master reset acts with no clock, so its check samples `q_o` a short time after `rst_ni` falls and before any rising edge. The first check after reset release is made one edge after release.

// File: rtl/quad_sr_latch_pkg.sv
package quad_sr_latch_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_CLR  = 2'd1,
    ACT_SET  = 2'd2
  } bit_act_e;

  // data-low dominates the set request
  function automatic bit_act_e decode_act(logic en_n, logic d, logic set_n);
    if (en_n)       return ACT_HOLD;
    else if (!d)    return ACT_CLR;
    else if (!set_n) return ACT_SET;
    else            return ACT_HOLD;
  endfunction
endpackage

// File: rtl/sr_act_decode.sv
module sr_act_decode
  import quad_sr_latch_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic                  en_ni,
  input  logic [WIDTH-1:0]      d_i,
  input  logic [WIDTH-1:0]      set_ni,
  output bit_act_e [WIDTH-1:0]  act_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_dec
    always_comb act_o[g] = decode_act(en_ni, d_i[g], set_ni[g]);
  end
endmodule

// File: rtl/sr_bit_cell.sv
module sr_bit_cell
  import quad_sr_latch_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  bit_act_e act_i,
  output logic     q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= 1'b0;
    else begin
      case (act_i)
        ACT_CLR: q_o <= 1'b0;
        ACT_SET: q_o <= 1'b1;
        default: q_o <= q_o;
      endcase
    end
  end

  always @(negedge clk_i) begin
    if (!rst_ni) assert_reset_low_R1: assert (q_o == 1'b0);
  end
endmodule

// File: rtl/quad_sr_latch.sv
module quad_sr_latch
  import quad_sr_latch_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_ni,
  input  logic [WIDTH-1:0] d_i,
  input  logic [WIDTH-1:0] set_ni,
  output logic [WIDTH-1:0] q_o
);
  bit_act_e [WIDTH-1:0] act;

  sr_act_decode #(.WIDTH(WIDTH)) u_dec (
    .en_ni (en_ni),
    .d_i   (d_i),
    .set_ni(set_ni),
    .act_o (act)
  );

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    sr_bit_cell u_cell (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .act_i (act[g]),
      .q_o   (q_o[g])
    );

    assert_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!en_ni && !d_i[g]) |=> !q_o[g]);
    assert_set_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!en_ni && d_i[g] && !set_ni[g]) |=> q_o[g]);
    assert_keep_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!en_ni && d_i[g] && set_ni[g]) |=> $stable(q_o[g]));
  end

  assert_disabled_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_ni |=> $stable(q_o));
endmodule

// File: tb/tb_quad_sr_latch.sv
module tb_quad_sr_latch;
  localparam int W = 4;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_n = 1'b1;
  logic [W-1:0] d = '0, s_n = '1, q, model = '0;
  int n_vec = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  quad_sr_latch #(.WIDTH(W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .en_ni(en_n),
    .d_i(d), .set_ni(s_n), .q_o(q)
  );

  function automatic logic next_bit(logic e, logic dd, logic ss, logic cur);
    if (e) return cur;
    if (!dd) return 1'b0;
    if (!ss) return 1'b1;
    return cur;
  endfunction

  function automatic string rule_tag(logic e, logic dd, logic ss);
    if (e) return "R2";
    if (!dd) return ss ? "R3" : "R3/R6";
    if (!ss) return "R4/R6";
    return "R5";
  endfunction

  task automatic chk(string tag, logic [W-1:0] exp);
    for (int b = 0; b < W; b++) begin
      n_vec++;
      if (q[b] !== exp[b]) begin
        n_bad++;
        $display("FAIL %s bit%0d: q=%b expected %b", tag, b, q[b], exp[b]);
      end
    end
  endtask

  // drive on falling edge, one rising edge, compare on next falling edge
  task automatic step(logic e, logic [W-1:0] dv, logic [W-1:0] sv, string extra);
    string tags[W];
    d = dv; s_n = sv; en_n = e;
    for (int b = 0; b < W; b++) begin
      model[b] = next_bit(e, dv[b], sv[b], model[b]);
      tags[b] = rule_tag(e, dv[b], sv[b]);
    end
    @(negedge clk);
    for (int b = 0; b < W; b++) begin
      n_vec++;
      if (q[b] !== model[b]) begin
        n_bad++;
        $display("FAIL %s%s bit%0d: q=%b expected %b", tags[b], extra, b, q[b], model[b]);
      end
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_1a7c));
    d = '1; s_n = '0; en_n = 1'b0;
    #3;
    chk("R1 reset", '0);
    @(negedge clk);
    chk("R1 reset held", '0);
    rst_n = 1'b1;
    model = '0;
    // R8: first edge after release already sets
    step(1'b0, 4'b1111, 4'b0000, " R8");
    // R7: mixed modes per bit
    step(1'b0, 4'b1010, 4'b0110, " R7");
    step(1'b0, 4'b1111, 4'b1111, " R5");
    step(1'b0, 4'b0000, 4'b0000, " R3 both low");
    step(1'b0, 4'b1111, 4'b1010, " R4");
    // R2: disabled, inputs ignored
    step(1'b1, 4'b0000, 4'b0000, " R2");
    step(1'b1, 4'b1111, 4'b0000, " R2");
    // R6: transparent D mode
    step(1'b0, 4'b0110, 4'b0000, " R6");
    step(1'b0, 4'b1001, 4'b0000, " R6");
    step(1'b1, 4'b0110, 4'b0000, " R8 keep last");
    chk("R8 disabled keeps last", 4'b1001);
    // R1 async mid-cycle
    #2 rst_n = 1'b0;
    #1 chk("R1 async", '0);
    model = '0;
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b0, 4'b0101, 4'b1100, " R8");
    for (int i = 0; i < 400; i++) begin
      step(1'($urandom_range(0, 3) == 0), 4'($urandom), 4'($urandom), " rand");
    end
    finish_run();
  end
endmodule